// File: doc/BRIEF.md
# PS/2 Keyboard Event Serializer

This block plays the keyboard's part on a PS/2 link for simulation or self-test. A single strobe carries a key event: an 8-bit scan code and a flag that says whether the key went down or came up. The block turns the event into the bytes a keyboard would send. A press gives one byte, the scan code. A release gives two bytes, the break prefix 0xF0 and then the scan code. It shifts each byte out as an 11-bit frame on open-collector-style clock and data lines.

The PS/2 clock comes from a divider of the system clock. A parameter sets the half-period in system cycles. With the default of 2000 cycles and a 50 MHz clock, the half-period is 40 µs. A second parameter sets how many idle half-periods are placed between the prefix and the scan code of a release. Busy stays high for the whole event. A strobe that arrives while busy is high is dropped. Shift keys need no special handling: left shift (0x12) and right shift (0x59) go through the same path as any other code.

Top module: `ps2_key_emitter`

## Requirements
- R1: After reset, and at any time busy is low, ps2_clk and ps2_dat are both 1.
- R2: A strobe with key_release=0, taken while idle, sends exactly one frame, and its data byte equals key_code.
- R3: A strobe with key_release=1, taken while idle, sends exactly two frames. The first data byte is 0xF0 and the second equals key_code.
- R4: Each frame has 11 bits, sampled on falling edges of ps2_clk. The order is: a start bit of 0, then data bits 0 to 7 (least significant first), then a parity bit that makes the nine data-plus-parity bits hold an odd number of ones, then a stop bit of 1.
- R5: ps2_dat changes only in cycles where ps2_clk is 1.
- R6: Inside a frame, consecutive falling edges of ps2_clk are exactly 2*HALF_DIV system cycles apart, and each high or low phase lasts HALF_DIV cycles.
- R7: In a release, the last falling edge of the 0xF0 frame and the first falling edge of the scan-code frame are exactly (GAP_HALVES+2)*HALF_DIV cycles apart. Both lines stay high during the gap.
- R8: busy goes high in the cycle after the strobe is taken. It stays high for exactly 22*HALF_DIV cycles for a press, or (44+GAP_HALVES)*HALF_DIV cycles for a release.
- R9: A strobe that arrives while busy is 1 is ignored. The bytes sent and the length of busy are unchanged, and no new transfer starts after busy falls.
- R10: The shift codes 0x12 and 0x59 get the same press and release sequences as any other code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| key_code | input | 8 | Scan code of the event |
| key_stb | input | 1 | One-cycle event strobe |
| key_release | input | 1 | 1 = key released, 0 = key pressed |
| ps2_clk | output | 1 | PS/2 clock line, idles high |
| ps2_dat | output | 1 | PS/2 data line, idles high |
| busy | output | 1 | High while an event is being sent |

## Verification
The bench sends all 256 scan codes, once as a press and once as a release. It decodes the frames on falling clock edges, so it checks byte values, bit order and parity, and odd-weight codes and even-weight codes exercise the parity bit in both states. Presses and releases of the same code differ in frame count, prefix, gap timing and busy length, so a missing prefix or a wrong gap shows up as a mismatch. Extra events are injected in the middle of a busy period with the other flag and a complemented code. Any corruption of the bytes or a transfer restarting afterwards is reported. The two shift codes are also checked on their own.

// File: rtl/ps2_key_emitter.sv
module ps2_key_emitter #(
  parameter int HALF_DIV   = 2000,
  parameter int GAP_HALVES = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] key_code,
  input  logic       key_stb,
  input  logic       key_release,
  output logic       ps2_clk,
  output logic       ps2_dat,
  output logic       busy
);
  localparam int DW = $clog2(HALF_DIV + 1);
  localparam int GW = $clog2(GAP_HALVES + 1);
  localparam logic [7:0] BREAK_PFX = 8'hF0;

  typedef enum logic [1:0] {S_IDLE, S_FRAME, S_GAP} st_t;

  st_t          st;
  logic [DW-1:0] div_cnt;
  logic [GW-1:0] gap_cnt;
  logic [3:0]   bit_idx;
  logic         phase;
  logic [10:0]  shreg;
  logic [7:0]   code_q;
  logic         need_code;

  function automatic logic [10:0] frame_of(input logic [7:0] b);
    return {1'b1, ~^b, b, 1'b0};
  endfunction

  wire tick = (div_cnt == DW'(HALF_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      div_cnt   <= '0;
      gap_cnt   <= '0;
      bit_idx   <= '0;
      phase     <= 1'b0;
      shreg     <= '1;
      code_q    <= '0;
      need_code <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (key_stb) begin
          st        <= S_FRAME;
          div_cnt   <= '0;
          bit_idx   <= '0;
          phase     <= 1'b0;
          code_q    <= key_code;
          need_code <= key_release;
          shreg     <= frame_of(key_release ? BREAK_PFX : key_code);
        end
        S_FRAME: begin
          div_cnt <= tick ? '0 : div_cnt + 1'b1;
          if (tick) begin
            if (!phase) phase <= 1'b1;
            else begin
              phase <= 1'b0;
              if (bit_idx == 4'd10) begin
                if (need_code) begin
                  st        <= S_GAP;
                  gap_cnt   <= '0;
                  shreg     <= frame_of(code_q);
                  need_code <= 1'b0;
                end else st <= S_IDLE;
              end else begin
                bit_idx <= bit_idx + 4'd1;
                shreg   <= shreg >> 1;
              end
            end
          end
        end
        S_GAP: begin
          div_cnt <= tick ? '0 : div_cnt + 1'b1;
          if (tick) begin
            if (gap_cnt == GW'(GAP_HALVES - 1)) begin
              st      <= S_FRAME;
              bit_idx <= '0;
              phase   <= 1'b0;
            end else gap_cnt <= gap_cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ps2_clk = !(st == S_FRAME && phase);
  assign ps2_dat = (st == S_FRAME) ? shreg[0] : 1'b1;
  assign busy    = (st != S_IDLE);
endmodule

// File: rtl/ps2_key_emitter_chk.sv
module ps2_key_emitter_chk (
  input logic clk,
  input logic rst_n,
  input logic key_stb,
  input logic ps2_clk,
  input logic ps2_dat,
  input logic busy
);
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ps2_clk && ps2_dat));

  a_r5_data_on_high: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ps2_dat) |-> ps2_clk);

  a_r8_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && key_stb) |=> (busy && !ps2_dat && ps2_clk));

  a_r6_clk_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ps2_clk) |-> busy);
endmodule

bind ps2_key_emitter ps2_key_emitter_chk u_chk (.*);

// File: tb/ps2_key_emitter_bench.sv
`timescale 1ns/1ps
module ps2_key_emitter_bench;
  localparam int H = 4;
  localparam int G = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] key_code = '0;
  logic key_stb = 1'b0;
  logic key_release = 1'b0;
  logic ps2_clk, ps2_dat, busy;

  always #5 clk = ~clk;

  ps2_key_emitter #(.HALF_DIV(H), .GAP_HALVES(G)) u_ps2_key_emitter (
    .clk(clk), .rst_n(rst_n), .key_code(key_code), .key_stb(key_stb),
    .key_release(key_release), .ps2_clk(ps2_clk), .ps2_dat(ps2_dat), .busy(busy));

  int n_chk = 0, n_fail = 0;
  int cyc = 0, last_fall = 0, nbits = 0, nbytes = 0;
  int frame_err = 0, chg_err = 0, ival_err = 0, busy_cnt = 0, gap_ival = 0;
  bit have_fall = 0;
  logic prev_clk = 1'b1, prev_dat = 1'b1;
  logic [10:0] frm;
  logic [7:0] got [0:3];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (busy) busy_cnt++;
      if (ps2_dat !== prev_dat && ps2_clk !== 1'b1) chg_err++;
      if (prev_clk && !ps2_clk) begin
        if (have_fall) begin
          if (nbits > 0 && cyc - last_fall != 2 * H) ival_err++;
          if (nbits == 0 && nbytes == 1) gap_ival = cyc - last_fall;
        end
        have_fall = 1;
        last_fall = cyc;
        frm[nbits] = ps2_dat;
        nbits++;
        if (nbits == 11) begin
          if (frm[0] !== 1'b0 || frm[10] !== 1'b1 || (^frm[9:1]) !== 1'b1) frame_err++;
          if (nbytes < 4) got[nbytes] = frm[8:1];
          nbytes++;
          nbits = 0;
        end
      end
    end
    prev_clk = ps2_clk;
    prev_dat = ps2_dat;
  end

  task automatic clear_mon();
    nbits = 0; nbytes = 0; frame_err = 0; chg_err = 0; ival_err = 0;
    busy_cnt = 0; gap_ival = 0; have_fall = 0;
  endtask

  task automatic run_event(input logic [7:0] c, input logic rel, input bit inject, input string req);
    int exp_busy;
    @(posedge clk); clear_mon();
    @(negedge clk); key_code = c; key_release = rel; key_stb = 1'b1;
    @(negedge clk); key_stb = 1'b0;
    if (inject) begin
      repeat (5) @(negedge clk);
      key_code = ~c; key_release = !rel; key_stb = 1'b1;
      @(negedge clk); key_stb = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (10) @(negedge clk);
    exp_busy = rel ? (44 + G) * H : 22 * H;
    chk(nbytes == (rel ? 2 : 1), req, "frame count", nbytes, rel ? 2 : 1);
    if (nbytes >= 1) chk(got[0] == (rel ? 8'hF0 : c), req, "first byte", got[0], rel ? 8'hF0 : c);
    if (rel && nbytes >= 2) chk(got[1] == c, "R3", "second byte", got[1], c);
    chk(frame_err == 0, "R4", "framing errors", frame_err, 0);
    chk(chg_err == 0, "R5", "data change with clock low", chg_err, 0);
    chk(ival_err == 0, "R6", "bit period errors", ival_err, 0);
    chk(busy_cnt == exp_busy, inject ? "R9" : "R8", "busy cycles", busy_cnt, exp_busy);
    if (rel) chk(gap_ival == (G + 2) * H, "R7", "inter-byte gap", gap_ival, (G + 2) * H);
    chk(ps2_clk && ps2_dat && !busy, "R1", "idle lines after event", {ps2_clk, ps2_dat, busy}, 3'b110);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ps2_clk === 1'b1 && ps2_dat === 1'b1 && busy === 1'b0, "R1", "reset state",
        {ps2_clk, ps2_dat, busy}, 3'b110);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ps2_clk === 1'b1 && ps2_dat === 1'b1 && busy === 1'b0, "R1", "idle after reset",
        {ps2_clk, ps2_dat, busy}, 3'b110);
    run_event(8'h12, 1'b0, 0, "R10");
    run_event(8'h12, 1'b1, 0, "R10");
    run_event(8'h59, 1'b0, 0, "R10");
    run_event(8'h59, 1'b1, 0, "R10");
    run_event(8'h1C, 1'b0, 1, "R9");
    run_event(8'h5A, 1'b1, 1, "R9");
    for (int k = 0; k < 256; k++) begin
      run_event(8'(k), 1'b0, 0, "R2");
      run_event(8'(k), 1'b1, 0, "R3");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule